// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Packing

This block buffers playback samples between a bus-side write port and a codec-side serializer. Software programs a small control field that holds the transmit enable, a data-slot enable, a sample-size code and a compact flag. Each 32-bit word written on the bus port is left-justified into a 20-bit entry and stored. In compact mode a single word carries two 16-bit halves, and these become two entries.

Output toward the codec happens in stereo pairs over a valid/ready handshake. A pair is offered only when transmit and the data slot are both enabled and at least half the FIFO is occupied. Once a pair has been taken, the block keeps offering pairs on the following cycles until fewer than two entries remain or the sink refuses one. After a refusal, draining waits again until the FIFO is half full. The block reports empty, half-empty, full and underrun status flags, which change on push and drain events. The depth is a parameter and must be a power of two of at least 8.

Top module: `audio_tx_fifo`

## Requirements
- R1: The 2-bit size code selects the sample width as follows: 0 is 16-bit, 1 is 18-bit, 2 is 20-bit and 3 is 12-bit. In non-compact mode a write stores one entry, which is the written word shifted left by 4, 2, 0 or 8 bits respectively and masked to 20 bits.
- R2: In compact mode a write stores two entries. Bits 15:0 are stored first and bits 31:16 second. Each half is shifted left by 8 when the size is 12-bit and by 4 otherwise.
- R3: When the control field is written with compact requested and a size code of 1 or 2, the block runs in non-compact mode.
- R4: A compact write is stored only when level+2 < DEPTH. A non-compact write is stored only when level < DEPTH. A write that is refused changes neither the stored data nor the level.
- R5: `pair_valid_o` is high only when transmit is enabled, the slot is enabled, and either level ≥ DEPTH/2 or a drain burst is in progress with level ≥ 2.
- R6: Pairs leave in write order, with the older entry on `pair_left_o`, at one pair per accepted handshake. A burst continues after an accepted pair while at least two entries remain. A refused offer ends the burst.
- R7: On any write attempt, the status flags are updated from the level after that write. A non-zero level clears empty and underrun, a level ≥ DEPTH/2 clears half-empty, and a level ≥ DEPTH sets full.
- R8: After an accepted pair, full clears. Half-empty sets if the level is ≤ DEPTH/2. Empty and underrun both set if the level is 0. These updates are applied after the write updates of the same cycle.
- R9: After reset the FIFO is empty, empty and half-empty are 1, full and underrun are 0, no pair is offered, and the control field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the control field |
| cfg_en_i | input | 1 | Transmit enable |
| cfg_slot_i | input | 1 | Data slot enable |
| cfg_size_i | input | 2 | Sample size code |
| cfg_compact_i | input | 1 | Compact mode request |
| wr_valid_i | input | 1 | Bus write strobe |
| wr_data_i | input | 32 | Bus write word |
| pair_ready_i | input | 1 | Sink accepts the offered pair |
| pair_valid_o | output | 1 | A stereo pair is offered |
| pair_left_o | output | 20 | Older entry of the pair |
| pair_right_o | output | 20 | Newer entry of the pair |
| empty_o | output | 1 | Empty flag |
| half_empty_o | output | 1 | Half-empty flag |
| full_o | output | 1 | Full flag |
| underrun_o | output | 1 | Underrun flag |

## Verification
The hardest cases to reach are the level boundaries. A compact write must be refused at level DEPTH-2 even though two slots are still free, and a burst must end with an odd single entry stranded below the half mark. The stimulus fills the FIFO with transmit disabled, then mixes compact and non-compact writes so that the level stops exactly at those edges. It then enables draining while the sink alternates between accepting and refusing. A long pseudo-random phase adds writes in the same cycle as drains and switches configuration mid-stream, and every cycle is compared against a queue-based model.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  localparam int SLOT_W = 20;

  typedef enum logic [1:0] {
    SZ_16 = 2'd0,
    SZ_18 = 2'd1,
    SZ_20 = 2'd2,
    SZ_12 = 2'd3
  } smp_size_e;

  // full-word sample, left-justified into a slot
  function automatic logic [SLOT_W-1:0] pad_word(smp_size_e sz, logic [19:0] w);
    unique case (sz)
      SZ_12:   pad_word = {w[11:0], 8'h00};
      SZ_16:   pad_word = {w[15:0], 4'h0};
      SZ_18:   pad_word = {w[17:0], 2'b00};
      default: pad_word = w;
    endcase
  endfunction

  // 16-bit half used in compact mode
  function automatic logic [SLOT_W-1:0] pad_half(smp_size_e sz, logic [15:0] h);
    if (sz == SZ_12) pad_half = {h[11:0], 8'h00};
    else             pad_half = {h, 4'h0};
  endfunction

endpackage

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl
  import audio_tx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  logic      en_i,
  input  logic      slot_i,
  input  logic [1:0] size_i,
  input  logic      compact_i,
  output logic      en_o,
  output logic      slot_o,
  output smp_size_e size_o,
  output logic      compact_o
);

  smp_size_e size_in;
  logic      compact_ok;

  assign size_in    = smp_size_e'(size_i);
  // wide samples cannot share a word
  assign compact_ok = compact_i && (size_in != SZ_18) && (size_in != SZ_20);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o      <= 1'b0;
      slot_o    <= 1'b0;
      size_o    <= SZ_16;
      compact_o <= 1'b0;
    end else if (we_i) begin
      en_o      <= en_i;
      slot_o    <= slot_i;
      size_o    <= size_in;
      compact_o <= compact_ok;
    end
  end

endmodule

// File: rtl/audio_tx_pack.sv
module audio_tx_pack
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic              wr_valid_i,
  input  logic [31:0]       data_i,
  input  smp_size_e         size_i,
  input  logic              compact_i,
  input  logic [LW-1:0]     level_i,
  output logic [1:0]        n_push_o,
  output logic [SLOT_W-1:0] ent0_o,
  output logic [SLOT_W-1:0] ent1_o
);

  localparam logic [LW:0] DEPTH_X = (LW+1)'(DEPTH);

  logic [SLOT_W-1:0] half_pad [2];
  logic [LW:0]       lvl_x;
  logic              room_one, room_two;

  for (genvar g = 0; g < 2; g++) begin : g_half
    assign half_pad[g] = pad_half(size_i, data_i[16*g +: 16]);
  end

  assign lvl_x    = {1'b0, level_i};
  assign room_one = lvl_x < DEPTH_X;
  assign room_two = (lvl_x + (LW+1)'(2)) < DEPTH_X;

  always_comb begin
    n_push_o = 2'd0;
    if (wr_valid_i) begin
      if (compact_i) n_push_o = room_two ? 2'd2 : 2'd0;
      else           n_push_o = room_one ? 2'd1 : 2'd0;
    end
  end

  assign ent0_o = compact_i ? half_pad[0] : pad_word(size_i, data_i[19:0]);
  assign ent1_o = half_pad[1];

endmodule

// File: rtl/audio_tx_store.sv
module audio_tx_store
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        n_push_i,
  input  logic [SLOT_W-1:0] d0_i,
  input  logic [SLOT_W-1:0] d1_i,
  input  logic              pop_i,
  output logic [SLOT_W-1:0] rd0_o,
  output logic [SLOT_W-1:0] rd1_o,
  output logic [LW-1:0]     level_o
);

  logic [SLOT_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [AW-1:0]     wptr_nx, rptr_nx;

  assign wptr_nx = wptr_q + AW'(1);
  assign rptr_nx = rptr_q + AW'(1);

  always_ff @(posedge clk_i) begin
    if (n_push_i != 2'd0) mem_q[wptr_q]  <= d0_i;
    if (n_push_i == 2'd2) mem_q[wptr_nx] <= d1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_o <= '0;
    end else begin
      wptr_q  <= wptr_q + AW'(n_push_i);
      rptr_q  <= rptr_q + (pop_i ? AW'(2) : AW'(0));
      level_o <= level_o + LW'(n_push_i) - (pop_i ? LW'(2) : LW'(0));
    end
  end

  assign rd0_o = mem_q[rptr_q];
  assign rd1_o = mem_q[rptr_nx];

endmodule

// File: rtl/audio_tx_status.sv
module audio_tx_status #(
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_try_i,
  input  logic [LW-1:0] lvl_push_i,
  input  logic          pop_i,
  input  logic [LW-1:0] lvl_post_i,
  output logic          empty_o,
  output logic          half_o,
  output logic          full_o,
  output logic          urun_o
);

  localparam logic [LW-1:0] HALF_L  = LW'(DEPTH / 2);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic e_n, h_n, f_n, u_n;

  // write effects first, drain effects override
  always_comb begin
    e_n = empty_o;
    h_n = half_o;
    f_n = full_o;
    u_n = urun_o;
    if (wr_try_i) begin
      if (lvl_push_i != '0) begin
        e_n = 1'b0;
        u_n = 1'b0;
      end
      if (lvl_push_i >= HALF_L)  h_n = 1'b0;
      if (lvl_push_i >= DEPTH_L) f_n = 1'b1;
    end
    if (pop_i) begin
      f_n = 1'b0;
      if (lvl_post_i <= HALF_L) h_n = 1'b1;
      if (lvl_post_i == '0) begin
        e_n = 1'b1;
        u_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_o <= 1'b1;
      half_o  <= 1'b1;
      full_o  <= 1'b0;
      urun_o  <= 1'b0;
    end else begin
      empty_o <= e_n;
      half_o  <= h_n;
      full_o  <= f_n;
      urun_o  <= u_n;
    end
  end

endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic        cfg_en_i,
  input  logic        cfg_slot_i,
  input  logic [1:0]  cfg_size_i,
  input  logic        cfg_compact_i,
  input  logic        wr_valid_i,
  input  logic [31:0] wr_data_i,
  input  logic        pair_ready_i,
  output logic        pair_valid_o,
  output logic [19:0] pair_left_o,
  output logic [19:0] pair_right_o,
  output logic        empty_o,
  output logic        half_empty_o,
  output logic        full_o,
  output logic        underrun_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [LW-1:0] HALF_L = LW'(DEPTH / 2);

  logic        en_q, slot_q, compact_q;
  smp_size_e   size_q;
  logic [1:0]  n_push;
  logic [SLOT_W-1:0] ent0, ent1;
  logic [LW-1:0] level_q, lvl_push, lvl_post;
  logic        fire, burst_q;

  audio_tx_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .en_i     (cfg_en_i),
    .slot_i   (cfg_slot_i),
    .size_i   (cfg_size_i),
    .compact_i(cfg_compact_i),
    .en_o     (en_q),
    .slot_o   (slot_q),
    .size_o   (size_q),
    .compact_o(compact_q)
  );

  audio_tx_pack #(.DEPTH(DEPTH), .LW(LW)) u_pack (
    .wr_valid_i(wr_valid_i),
    .data_i    (wr_data_i),
    .size_i    (size_q),
    .compact_i (compact_q),
    .level_i   (level_q),
    .n_push_o  (n_push),
    .ent0_o    (ent0),
    .ent1_o    (ent1)
  );

  audio_tx_store #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .n_push_i(n_push),
    .d0_i    (ent0),
    .d1_i    (ent1),
    .pop_i   (fire),
    .rd0_o   (pair_left_o),
    .rd1_o   (pair_right_o),
    .level_o (level_q)
  );

  // burst keeps draining below the half mark after the first accepted pair
  assign pair_valid_o = en_q && slot_q &&
                        ((level_q >= HALF_L) || (burst_q && (level_q >= LW'(2))));
  assign fire     = pair_valid_o && pair_ready_i;
  assign lvl_push = level_q + LW'(n_push);
  assign lvl_post = lvl_push - (fire ? LW'(2) : LW'(0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) burst_q <= 1'b0;
    else         burst_q <= fire && (lvl_post >= LW'(2));
  end

  audio_tx_status #(.DEPTH(DEPTH), .LW(LW)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_try_i  (wr_valid_i),
    .lvl_push_i(lvl_push),
    .pop_i     (fire),
    .lvl_post_i(lvl_post),
    .empty_o   (empty_o),
    .half_o    (half_empty_o),
    .full_o    (full_o),
    .urun_o    (underrun_o)
  );

endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          slot_i,
  input logic [1:0]    size_i,
  input logic          compact_i,
  input logic [LW-1:0] level_i,
  input logic          pair_valid_o,
  input logic          pair_ready_i,
  input logic          empty_o,
  input logic          full_o
);

  p_valid_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> (en_i && slot_i));

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= LW'(DEPTH));

  p_full_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !(pair_valid_o && pair_ready_i)) |=> full_o);

  p_pop_clears_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && pair_ready_i) |=> !full_o);

  p_empty_no_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pair_valid_o);

  p_compact_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compact_i |-> (size_i == 2'd0 || size_i == 2'd3));

endmodule

bind audio_tx_fifo audio_tx_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_q),
  .slot_i      (slot_q),
  .size_i      (size_q),
  .compact_i   (compact_q),
  .level_i     (level_q),
  .pair_valid_o(pair_valid_o),
  .pair_ready_i(pair_ready_i),
  .empty_o     (empty_o),
  .full_o      (full_o)
);

// File: tb/audio_tx_fifo_bench.sv
module audio_tx_fifo_bench;

  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 0, cfg_en = 0, cfg_slot = 0, cfg_compact = 0;
  logic [1:0]  cfg_size = 0;
  logic        wr_valid = 0, pair_ready = 0;
  logic [31:0] wr_data = 0;
  logic        pair_valid, empty, half_empty, full, underrun;
  logic [19:0] pair_left, pair_right;

  audio_tx_fifo #(.DEPTH(DEPTH)) u_audio_tx_fifo (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_en_i(cfg_en), .cfg_slot_i(cfg_slot),
    .cfg_size_i(cfg_size), .cfg_compact_i(cfg_compact),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .pair_ready_i(pair_ready),
    .pair_valid_o(pair_valid), .pair_left_o(pair_left), .pair_right_o(pair_right),
    .empty_o(empty), .half_empty_o(half_empty), .full_o(full), .underrun_o(underrun)
  );

  int q[$];
  bit m_en = 0, m_slot = 0, m_comp = 0, m_burst = 0;
  int m_bits = 16;
  bit m_e = 1, m_h = 1, m_f = 0, m_u = 0;
  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int code_bits(logic [1:0] c);
    case (c)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 12;
    endcase
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=0x%0h exp=0x%0h t=%0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic bit model_valid();
    return m_en && m_slot && (q.size() >= HALF || (m_burst && q.size() >= 2));
  endfunction

  task automatic compare();
    bit mv = model_valid();
    chk("R5", "pair_valid", int'(pair_valid), int'(mv));
    if (mv && pair_valid) begin
      chk(cur_req, "left", int'(pair_left), q[0]);
      chk(cur_req, "right", int'(pair_right), q[1]);
    end
    chk("R7 R8", "empty", int'(empty), int'(m_e));
    chk("R7 R8", "half_empty", int'(half_empty), int'(m_h));
    chk("R7 R8", "full", int'(full), int'(m_f));
    chk("R7 R8", "underrun", int'(underrun), int'(m_u));
  endtask

  task automatic model_step();
    int n = q.size();
    bit fire = model_valid() && pair_ready;
    int sh = 20 - m_bits;
    if (wr_valid) begin
      if (m_comp) begin
        if (n + 2 < DEPTH) begin
          q.push_back((int'(wr_data[15:0]) << sh) & 'hFFFFF);
          q.push_back((int'(wr_data[31:16]) << sh) & 'hFFFFF);
        end
      end else if (n < DEPTH) begin
        q.push_back((int'(wr_data) << sh) & 'hFFFFF);
      end
      if (q.size() > 0) begin m_e = 0; m_u = 0; end
      if (q.size() >= HALF)  m_h = 0;
      if (q.size() >= DEPTH) m_f = 1;
    end
    if (fire) begin
      void'(q.pop_front());
      void'(q.pop_front());
      m_f = 0;
      if (q.size() <= HALF) m_h = 1;
      if (q.size() == 0) begin m_e = 1; m_u = 1; end
    end
    m_burst = fire && q.size() >= 2;
    if (cfg_we) begin
      m_en   = cfg_en;
      m_slot = cfg_slot;
      m_bits = code_bits(cfg_size);
      m_comp = cfg_compact && (m_bits == 12 || m_bits == 16);
    end
  endtask

  task automatic tick();
    compare();
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(bit en, bit slot, logic [1:0] sz, bit comp);
    cfg_we = 1; cfg_en = en; cfg_slot = slot; cfg_size = sz; cfg_compact = comp;
    tick();
    cfg_we = 0;
  endtask

  task automatic push(logic [31:0] d);
    wr_valid = 1; wr_data = d;
    tick();
    wr_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL all watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk("R9", "reset empty", int'(empty), 1);
    chk("R9", "reset half_empty", int'(half_empty), 1);
    chk("R9", "reset full", int'(full), 0);
    chk("R9", "reset underrun", int'(underrun), 0);
    chk("R9", "reset pair_valid", int'(pair_valid), 0);

    // R1 every size, non-compact, sink always ready
    cur_req = "R1";
    pair_ready = 1;
    for (int c = 0; c < 4; c++) begin
      set_cfg(1, 1, 2'(c), 0);
      for (int i = 0; i < 4; i++) push(32'hFFF5A3C7 ^ (i * 32'h1357_0F1D));
      idle(4);
    end

    // R2 compact packing for 16 and 12 bits
    cur_req = "R2";
    set_cfg(1, 1, 2'd0, 1);
    push(32'hBEEF_1234); push(32'h8001_7FFE);
    idle(4);
    set_cfg(1, 1, 2'd3, 1);
    push(32'hFABC_0DEF); push(32'h0123_CDEF);
    idle(4);

    // R3 compact request with wide sizes
    cur_req = "R3";
    for (int c = 1; c < 3; c++) begin
      set_cfg(1, 1, 2'(c), 1);
      for (int i = 0; i < 4; i++) push(32'hA5A5_3C3C + i * 32'h0101_0101);
      idle(4);
    end

    // R4 fill with transmit off, overflow drops
    cur_req = "R4";
    set_cfg(0, 1, 2'd0, 0);
    for (int i = 0; i < DEPTH + 2; i++) push(32'h1000 + i);
    idle(2);
    set_cfg(1, 1, 2'd0, 0);
    idle(6);
    set_cfg(0, 1, 2'd3, 1);
    for (int i = 0; i < 4; i++) push(32'h0ABC_0123 + i * 32'h0011_0022);
    set_cfg(0, 1, 2'd3, 0);
    for (int i = 0; i < 3; i++) push(32'h0000_0F00 + i);

    // R6 refusals end bursts, order kept
    cur_req = "R6";
    pair_ready = 0;
    set_cfg(1, 1, 2'd3, 0);
    idle(3);
    for (int i = 0; i < 12; i++) begin
      pair_ready = i[0];
      tick();
    end
    pair_ready = 1;
    push(32'h0000_0AAA); push(32'h0000_0555);
    idle(4);

    // R5 slot disabled blocks drain
    cur_req = "R5";
    set_cfg(1, 0, 2'd0, 0);
    for (int i = 0; i < 6; i++) push(32'h0000_4000 + i);
    idle(3);
    set_cfg(1, 1, 2'd0, 0);
    idle(6);

    // mixed traffic, concurrent write and drain
    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 200 == 0) begin
        cfg_we = 1; cfg_en = (lfsr[9:8] != 0); cfg_slot = 1;
        cfg_size = lfsr[2:1]; cfg_compact = lfsr[7];
      end else cfg_we = 0;
      wr_valid = lfsr[0] | lfsr[11];
      wr_data = {lfsr, ~lfsr ^ 16'(i)};
      pair_ready = lfsr[3] | lfsr[5];
      tick();
    end
    cfg_we = 0; wr_valid = 0;
    idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule